// File: doc/BRIEF.md
# Instruction Target Address Calculation Unit

This unit sits in the decode stage of a processor with 24-bit registers and byte-addressed memory of up to 2^20 bytes. It takes the leading four bytes of an instruction word together with the current instruction address and the base and index registers. One clock later it presents three results: the effective target address, the instruction length, and the kind of operand access the instruction asks for.

Two flag bits select how the target address is used. The address can be the operand itself (immediate). It can point at a word that holds the operand's address (indirect). It can point at the operand (simple). When both flags are clear, the instruction is in the older short format, which uses a plain 15-bit address. Three more flags select the displacement base and the field width: a base-register-relative displacement, a displacement relative to the following instruction, a plain field, or a 20-bit extended field. Combinations that make no sense are flagged as illegal. Fetching the operand, following the indirect pointer and executing the operation belong to later stages.

Top module: `tgt_addr_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `valid_o`, `opcode_o`, `tgt_o`, `len_o`, `mode_o` and `illegal_o` are all zero.
- R2: The outputs are registered with one cycle of latency. `valid_o` equals `valid_i` of the previous cycle. A cycle with `valid_i` low leaves all other outputs unchanged, whatever `instr_i` and the register inputs carry.
- R3: The access mode comes from bits 25 (n) and 24 (i) of `instr_i`, and `opcode_o` returns bits 31:26. The encoding of `mode_o` is:
  - n=1, i=1 gives 0 (simple).
  - n=0, i=1 gives 1 (immediate).
  - n=1, i=0 gives 2 (indirect).
  - n=0, i=0 gives 3 (legacy).
- R4: `len_o` is 4 when bit 20 (e) is set and the mode is not legacy. Otherwise it is 3.
- R5: With e=0, bit 22 (b)=0 and bit 21 (p)=0 in a non-legacy mode, the target is the 12-bit displacement in bits 19:8, zero-extended.
- R6: With b=1, p=0 and e=0, the target is `base_i` plus the unsigned displacement.
- R7: With b=0, p=1 and e=0, the target is `pc_i` + 3 plus the sign-extended displacement. `pc_i` is the address of the instruction being decoded.
- R8: With e=1 and b=p=0 in a non-legacy mode, the target is the 20-bit field in bits 19:0.
- R9: When bit 23 (x) is set, `index_i` is added to the target in every non-illegal case, legacy included.
- R10: In legacy mode, bits 22:8 form a 15-bit absolute address. The b, p and e bits are not decoded as flags in this mode.
- R11: In a non-legacy mode, `illegal_o` is raised when b=p=1, or when e=1 together with b or p. `tgt_o` is then 0. `illegal_o` is never raised in legacy mode.
- R12: All address sums are taken modulo 2^20. Only the low 20 bits of `base_i` and `index_i` take part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Leading instruction bytes, first byte in bits 31:24 |
| pc_i | input | 20 | Address of the instruction being decoded |
| base_i | input | 24 | Base register value |
| index_i | input | 24 | Index register value |
| valid_o | output | 1 | Result valid |
| opcode_o | output | 6 | Opcode bits of the decoded instruction |
| tgt_o | output | 20 | Effective target address |
| len_o | output | 3 | Instruction length in bytes |
| mode_o | output | 2 | Operand access mode |
| illegal_o | output | 1 | Illegal flag combination |

## Verification
The bench aims at the corners where the flag fields interact.

- **Negative PC-relative displacement.** A design that zero-extends it lands about 4 KiB too high.
- **Legacy words with b, p or e set.** A design that still decodes those bits as flags reports a 4-byte length, a relative target or a false illegal flag.
- **Base plus index near the top of the space.** A design without modulo-2^20 wraparound gets the target wrong there.
- **Idle cycles carrying changed inputs.** Any leak from these shows up as output that moves without `valid_i`.

// File: rtl/tau_pkg.sv
package tau_pkg;
    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int NFLAG    = 6;
    localparam int EXT_W    = INSTR_W - OPC_W - NFLAG;
    localparam int DISP_W   = 12;
    localparam int DISP_LO  = EXT_W - DISP_W;
    localparam int BIT_N    = INSTR_W - OPC_W - 1;
    localparam int BIT_I    = BIT_N - 1;
    localparam int BIT_X    = BIT_N - 2;
    localparam int BIT_B    = BIT_N - 3;
    localparam int BIT_P    = BIT_N - 4;
    localparam int BIT_E    = BIT_N - 5;
    localparam int LEG_W    = BIT_B - DISP_LO + 1;
    localparam int LEN_W    = 3;
    localparam int SHORT_LEN = 3;
    localparam int LONG_LEN  = 4;

    typedef enum logic [1:0] {
        ACC_SIMPLE = 2'd0,
        ACC_IMM    = 2'd1,
        ACC_IND    = 2'd2,
        ACC_LEGACY = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_PC   = 2'd1,
        BASE_REG  = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        FLD_DISP_U = 2'd0,
        FLD_DISP_S = 2'd1,
        FLD_EXT    = 2'd2,
        FLD_LEG    = 2'd3
    } fld_sel_e;

    typedef struct packed {
        acc_mode_e        mode;
        base_sel_e        base_sel;
        fld_sel_e         fld_sel;
        logic             use_index;
        logic             illegal;
        logic [LEN_W-1:0] len;
    } dec_t;
endpackage

// File: rtl/tau_flag_decode.sv
module tau_flag_decode
    import tau_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic fn, fi, fx, fb, fp, fe, legacy;

    assign fn = instr_i[BIT_N];
    assign fi = instr_i[BIT_I];
    assign fx = instr_i[BIT_X];
    assign fb = instr_i[BIT_B];
    assign fp = instr_i[BIT_P];
    assign fe = instr_i[BIT_E];
    assign legacy = !fn && !fi;

    always_comb begin
        dec_o.use_index = fx;
        dec_o.illegal   = 1'b0;
        dec_o.base_sel  = BASE_NONE;
        dec_o.fld_sel   = FLD_DISP_U;
        dec_o.len       = LEN_W'(SHORT_LEN);
        unique case ({fn, fi})
            2'b11:   dec_o.mode = ACC_SIMPLE;
            2'b01:   dec_o.mode = ACC_IMM;
            2'b10:   dec_o.mode = ACC_IND;
            default: dec_o.mode = ACC_LEGACY;
        endcase
        if (legacy) begin
            dec_o.fld_sel = FLD_LEG;
        end else begin
            dec_o.illegal = (fb && fp) || (fe && (fb || fp));
            if (fe) begin
                dec_o.len     = LEN_W'(LONG_LEN);
                dec_o.fld_sel = FLD_EXT;
            end else if (fb && !fp) begin
                dec_o.base_sel = BASE_REG;
            end else if (fp && !fb) begin
                dec_o.base_sel = BASE_PC;
                dec_o.fld_sel  = FLD_DISP_S;
            end
        end
    end
endmodule

// File: rtl/tau_addr_gen.sv
module tau_addr_gen
    import tau_pkg::*;
#(
    parameter int ADDR_W = tau_pkg::EXT_W,
    parameter int REG_W  = 24
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  dec_t               dec_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [REG_W-1:0]   base_i,
    input  logic [REG_W-1:0]   index_i,
    output logic [ADDR_W-1:0]  tgt_o
);
    localparam int SX_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] field_v, base_v, index_v;

    assign disp = instr_i[DISP_LO +: DISP_W];

    always_comb begin
        unique case (dec_i.fld_sel)
            FLD_DISP_S: field_v = {{SX_W{disp[DISP_W-1]}}, disp};
            FLD_EXT:    field_v = ADDR_W'(instr_i[EXT_W-1:0]);
            FLD_LEG:    field_v = ADDR_W'(instr_i[BIT_B:DISP_LO]);
            default:    field_v = ADDR_W'(disp);
        endcase
        unique case (dec_i.base_sel)
            BASE_PC:  base_v = pc_i + ADDR_W'(SHORT_LEN);
            BASE_REG: base_v = base_i[ADDR_W-1:0];
            default:  base_v = '0;
        endcase
        index_v = dec_i.use_index ? index_i[ADDR_W-1:0] : '0;
        tgt_o   = dec_i.illegal ? '0 : (field_v + base_v + index_v);
    end
endmodule

// File: rtl/tgt_addr_unit.sv
module tgt_addr_unit
    import tau_pkg::*;
#(
    parameter int ADDR_W = tau_pkg::EXT_W,
    parameter int REG_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [REG_W-1:0]     base_i,
    input  logic [REG_W-1:0]     index_i,
    output logic                 valid_o,
    output logic [OPC_W-1:0]     opcode_o,
    output logic [ADDR_W-1:0]    tgt_o,
    output logic [LEN_W-1:0]     len_o,
    output logic [1:0]           mode_o,
    output logic                 illegal_o
);
    typedef struct packed {
        logic              valid;
        logic [OPC_W-1:0]  opc;
        logic [ADDR_W-1:0] tgt;
        logic [LEN_W-1:0]  len;
        acc_mode_e         mode;
        logic              illegal;
    } out_t;

    dec_t              dec;
    logic [ADDR_W-1:0] tgt_calc;
    out_t              out_d, out_q;

    tau_flag_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    tau_addr_gen #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W)
    ) u_agen (
        .instr_i (instr_i),
        .dec_i   (dec),
        .pc_i    (pc_i),
        .base_i  (base_i),
        .index_i (index_i),
        .tgt_o   (tgt_calc)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = valid_i;
        if (valid_i) begin
            out_d.opc     = instr_i[INSTR_W-1 -: OPC_W];
            out_d.tgt     = tgt_calc;
            out_d.len     = dec.len;
            out_d.mode    = dec.mode;
            out_d.illegal = dec.illegal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o   = out_q.valid;
    assign opcode_o  = out_q.opc;
    assign tgt_o     = out_q.tgt;
    assign len_o     = out_q.len;
    assign mode_o    = out_q.mode;
    assign illegal_o = out_q.illegal;
endmodule

// File: rtl/tgt_addr_unit_chk.sv
module tgt_addr_unit_chk
    import tau_pkg::*;
#(
    parameter int ADDR_W = tau_pkg::EXT_W,
    parameter int REG_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic               valid_o,
    input logic [OPC_W-1:0]   opcode_o,
    input logic [ADDR_W-1:0]  tgt_o,
    input logic [LEN_W-1:0]   len_o,
    input logic [1:0]         mode_o,
    input logic               illegal_o
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(tgt_o) && $stable(len_o)
                      && $stable(mode_o) && $stable(illegal_o) && $stable(opcode_o)));

    // R3
    imm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !instr_i[BIT_N] && instr_i[BIT_I]) |=> (mode_o == 2'd1));

    // R4
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (len_o == 3'd3 || len_o == 3'd4));

    // R10
    legacy_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mode_o == 2'd3) |-> (len_o == 3'd3 && !illegal_o));

    // R11
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && illegal_o) |-> (tgt_o == '0));
endmodule

bind tgt_addr_unit tgt_addr_unit_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .valid_o   (valid_o),
    .opcode_o  (opcode_o),
    .tgt_o     (tgt_o),
    .len_o     (len_o),
    .mode_o    (mode_o),
    .illegal_o (illegal_o)
);

// File: tb/test_tgt_addr_unit.sv
module test_tgt_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [31:0] instr_i;
    logic [19:0] pc_i;
    logic [23:0] base_i, index_i;
    logic        valid_o;
    logic [5:0]  opcode_o;
    logic [19:0] tgt_o;
    logic [2:0]  len_o;
    logic [1:0]  mode_o;
    logic        illegal_o;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    tgt_addr_unit i_tgt_addr_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .base_i(base_i), .index_i(index_i), .valid_o(valid_o),
        .opcode_o(opcode_o), .tgt_o(tgt_o), .len_o(len_o), .mode_o(mode_o),
        .illegal_o(illegal_o)
    );

    function automatic logic [31:0] mk(logic [5:0] opc, logic n, logic i, logic x,
                                       logic b, logic p, logic e, logic [19:0] fld);
        return {opc, n, i, x, b, p, e, fld};
    endfunction

    // packed expected: {valid, opcode, illegal, mode, len, tgt}
    function automatic logic [32:0] model(logic [31:0] w, logic [19:0] pc,
                                          logic [23:0] bs, logic [23:0] ix);
        logic n, i, x, b, p, e, ill;
        logic [1:0]  md;
        logic [2:0]  ln;
        logic [19:0] t;
        logic [11:0] d;
        n = w[25]; i = w[24]; x = w[23]; b = w[22]; p = w[21]; e = w[20];
        d = w[19:8];
        if (!n && !i) begin
            md = 2'd3; ln = 3'd3; ill = 1'b0;
            t = {5'b0, w[22:8]};
            if (x) t = t + ix[19:0];
        end else begin
            md  = (n && i) ? 2'd0 : (i ? 2'd1 : 2'd2);
            ln  = e ? 3'd4 : 3'd3;
            ill = (b && p) || (e && (b || p));
            if (e)      t = w[19:0];
            else if (b) t = bs[19:0] + {8'b0, d};
            else if (p) t = pc + 20'd3 + {{8{d[11]}}, d};
            else        t = {8'b0, d};
            if (x) t = t + ix[19:0];
            if (ill) t = '0;
        end
        return {1'b1, w[31:26], ill, md, ln, t};
    endfunction

    function automatic string tag_of(logic [31:0] w);
        if (!w[25] && !w[24]) return "R10";
        if ((w[22] && w[21]) || (w[20] && (w[22] || w[21]))) return "R11";
        if (w[23]) return "R9";
        if (w[20]) return "R8";
        if (w[22]) return "R6";
        if (w[21]) return "R7";
        return "R5";
    endfunction

    function automatic logic [32:0] actual();
        return {valid_o, opcode_o, illegal_o, mode_o, len_o, tgt_o};
    endfunction

    task automatic chk(string tag, logic [32:0] act, logic [32:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [32:0] last_exp;

    task automatic apply(string tag, logic [31:0] w, logic [19:0] pc,
                         logic [23:0] bs, logic [23:0] ix);
        valid_i = 1'b1; instr_i = w; pc_i = pc; base_i = bs; index_i = ix;
        last_exp = model(w, pc, bs, ix);
        @(negedge clk);
        chk(tag, actual(), last_exp);
    endtask

    task automatic idle(string tag);
        valid_i = 1'b0;
        instr_i = $urandom; pc_i = 20'($urandom); base_i = 24'($urandom); index_i = 24'($urandom);
        @(negedge clk);
        chk(tag, actual(), {1'b0, last_exp[31:0]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        rst_n = 1'b0; valid_i = 1'b1; instr_i = 32'hFFFF_FFFF;
        pc_i = '1; base_i = '1; index_i = '1;
        repeat (3) @(negedge clk);
        // R1: reset clears every output
        chk("R1", actual(), 33'd0);
        valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", actual(), 33'd0);

        // R3: each access mode
        apply("R3", mk(6'h0C, 1, 1, 0, 0, 0, 0, 20'h12300), 20'h0, 24'h0, 24'h0);
        apply("R3", mk(6'h01, 0, 1, 0, 0, 0, 0, 20'h00500), 20'h0, 24'h0, 24'h0);
        apply("R3", mk(6'h3F, 1, 0, 0, 0, 0, 0, 20'hABC00), 20'h0, 24'h0, 24'h0);
        // R5: plain displacement
        apply("R5", mk(6'h00, 1, 1, 0, 0, 0, 0, 20'hFFF00), 20'h5000, 24'h9000, 24'h0);
        // R6: base relative, top displacement bit is not a sign
        apply("R6", mk(6'h00, 1, 1, 0, 1, 0, 0, 20'h80000), 20'h0, 24'h01_0000, 24'h0);
        // R7: PC relative with a negative displacement
        apply("R7", mk(6'h00, 1, 1, 0, 0, 1, 0, 20'hFFD00), 20'h01000, 24'h0, 24'h0);
        apply("R7", mk(6'h00, 0, 1, 0, 0, 1, 0, 20'h7FF00), 20'h00100, 24'h0, 24'h0);
        // R4 / R8: extended format
        apply("R8", mk(6'h12, 1, 1, 0, 0, 0, 1, 20'hFEDCB), 20'h0, 24'h0, 24'h0);
        // R9: index added in extended, base relative and legacy
        apply("R9", mk(6'h12, 1, 1, 1, 0, 0, 1, 20'h10000), 20'h0, 24'h0, 24'hFF0010);
        apply("R9", mk(6'h12, 1, 0, 1, 1, 0, 0, 20'h00100), 20'h0, 24'h200, 24'h30);
        // R10: legacy with b, p, e set reinterpreted as address bits
        apply("R10", mk(6'h05, 0, 0, 0, 1, 1, 1, 20'hABC00), 20'h0, 24'h0, 24'h0);
        apply("R10", mk(6'h05, 0, 0, 1, 1, 0, 1, 20'h00100), 20'h0, 24'h0, 24'h7);
        // R11: illegal combinations
        apply("R11", mk(6'h05, 1, 1, 0, 1, 1, 0, 20'h12300), 20'h0, 24'h10, 24'h0);
        apply("R11", mk(6'h05, 1, 0, 1, 1, 0, 1, 20'h12345), 20'h0, 24'h10, 24'h1);
        apply("R11", mk(6'h05, 0, 1, 0, 0, 1, 1, 20'h12345), 20'h0, 24'h10, 24'h1);
        // R12: wraparound at the top of the address space
        apply("R12", mk(6'h00, 1, 1, 1, 1, 0, 0, 20'h00500), 20'h0, 24'hAF_FFFF, 24'h00_0001);
        apply("R12", mk(6'h00, 1, 1, 0, 0, 1, 0, 20'h00A00), 20'hFFFFE, 24'h0, 24'h0);
        // R2: idle cycles hold results
        idle("R2");
        idle("R2");

        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (($urandom % 8) == 0) idle("R2");
            else apply(tag_of(w), w, 20'($urandom), 24'($urandom), 24'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule